// File: doc/BRIEF.md
# Threshold-Interrupt Sample Buffer

This block buffers conversion results between a converter that produces one result per clock and a host that drains results in bursts. Each result is a 14-bit code plus an out-of-range bit. While the buffer is enabled, a result that arrives with its valid strobe is stored in a 16-entry circular store. Each host read strobe moves the oldest stored result onto the read port. The host can then leave the converter running and service a whole burst of results from a single interrupt, without being interrupted once per sample.

The interrupt level is programmed as a 4-bit code, and the level equals twice that code. The interrupt becomes active when the stored count reaches the level. It goes inactive only when a host read leaves fewer results than the level. When the store holds 16 results, the overflow pin is active and a status bit latches. That bit stays set until the block is disabled or reset. Results that arrive while the store is full and not being read are discarded, so unread data is never overwritten. Each of the two pins has its own polarity input.

With the enable low, the store is held empty and both flags are cleared. The read port then becomes a plain register that captures the converter's output on every clock, so a host can use the converter without buffering.

Top module: `sample_irq_fifo`

## Requirements
- R1: While `rst_n` is low, `rd_data` and `rd_oor` are 0, `ovf_sticky` is 0, and both pins sit at their inactive level.
- R2: While `fifo_en` is 0, `{rd_oor, rd_data}` takes the value of `{smp_oor, smp_data}` one clock later on every clock, whatever `smp_valid` and `rd_req` are. In the same mode the store is emptied and the interrupt flag and `ovf_sticky` are cleared.
- R3: While enabled, results written with `smp_valid` come out in arrival order. A `rd_req` in cycle n, with the store not empty, presents the oldest result on `rd_data`/`rd_oor` after the clock edge that ends cycle n, and that value holds until the next accepted read.
- R4: A `rd_req` while the store is empty leaves `rd_data`/`rd_oor` at the last value and consumes nothing. The next result written is the next one read.
- R5: The interrupt level is 2 × `thr_code`, so it ranges from 0 to 30. The interrupt flag is set at the clock edge after which the stored count is greater than or equal to that level.
- R6: Once set, the interrupt flag stays set through writes, idle cycles and changes to `thr_code`. It is cleared only by an accepted read that leaves the count below the level, or by disabling the block.
- R7: The overflow flag is active exactly while the store holds 16 results. A result that arrives while the store is full, in a cycle with no accepted read, is discarded, and the 16 stored results are read out unchanged.
- R8: `ovf_sticky` is set at the edge where the count reaches 16. It stays at 1, even after the store drains, until `fifo_en` is 0 or `rst_n` is low.
- R9: Each pin carries its flag when its polarity input is 1 (active high) and the inverse of its flag when the polarity input is 0 (active low). A change of polarity shows on the pin in the same cycle.
- R10: When the store is full, a write and an accepted read in the same cycle both take effect. The count stays at 16 and the new result is queued behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | 1 = buffered mode, 0 = store held empty and per-clock pass-through |
| smp_data | input | 14 | Conversion result |
| smp_oor | input | 1 | Out-of-range bit belonging to the result |
| smp_valid | input | 1 | Result on `smp_data` is new this cycle |
| rd_req | input | 1 | Host read strobe, one cycle per result |
| thr_code | input | 4 | Interrupt level code, level = 2 × code |
| irq_pol | input | 1 | Interrupt pin polarity, 1 = active high |
| ovf_pol | input | 1 | Overflow pin polarity, 1 = active high |
| rd_data | output | 14 | Result presented to the host |
| rd_oor | output | 1 | Out-of-range bit of the presented result |
| irq_pin | output | 1 | Interrupt pin after polarity |
| ovf_pin | output | 1 | Full/overflow pin after polarity |
| ovf_sticky | output | 1 | Latched overflow status |

## Verification
The bench drives the boundary cases of the fill count against a queue model. These include the count sitting exactly at the level, a level above the 16-entry capacity, and a level of zero. A design that used a strict comparison, or a level equal to the code instead of twice the code, would move the interrupt edge by one or more results. The bench raises `thr_code` while the flag is set and also keeps writing. A design that re-evaluated the flag every cycle would drop the interrupt without any read. Writes into a full store, with and without a read in the same cycle, catch a design that overwrites the oldest result or refuses a write it could accept. Reads from an empty store catch a pointer that wraps past the write side and replays stale data.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

   // storage implementation variants
   typedef enum logic {
      STORE_BANK  = 1'b0,   // one register per entry, explicit read mux
      STORE_ARRAY = 1'b1    // single inferred array
   } store_style_e;

   // drive a pin from an internal flag under a polarity select
   function automatic logic drive_level(input logic flag, input logic active_high);
      return active_high ? flag : ~flag;
   endfunction

endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
   parameter int                     WORD_W = 15,
   parameter int                     ADDR_W = 4,
   parameter sfifo_pkg::store_style_e STYLE  = sfifo_pkg::STORE_BANK
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (WORD_W >= 1) else $error("sfifo_store: WORD_W must be at least 1");
      assert (ADDR_W >= 1 && ADDR_W <= 10) else $error("sfifo_store: ADDR_W out of range");
   end

   generate
      if (STYLE == sfifo_pkg::STORE_BANK) begin : g_bank
         logic [DEPTH-1:0][WORD_W-1:0] ent_w;
         for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
               if (wr_en && (wr_addr == ADDR_W'(i))) begin
                  word_q <= wr_word;
               end
            end
            assign ent_w[i] = word_q;
         end
         assign rd_word = ent_w[rd_addr];
      end else begin : g_array
         logic [WORD_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (wr_en) begin
               mem[wr_addr] <= wr_word;
            end
         end
         assign rd_word = mem[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
   parameter int ADDR_W    = 4,
   parameter int THR_W     = 4,
   parameter int LVL_SHIFT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_req,
   input  logic              rd_req,
   input  logic [THR_W-1:0]  thr_code,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_fire,
   output logic              rd_fire,
   output logic              irq_flag,
   output logic              full_flag,
   output logic              ovf_sticky
);

   localparam int PTR_W = ADDR_W + 1;              // extra bit tells full from empty
   localparam int LVL_W = THR_W + LVL_SHIFT;
   localparam int CMP_W = (PTR_W > LVL_W) ? PTR_W : LVL_W;
   localparam logic [PTR_W-1:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};
   localparam logic [PTR_W-1:0] ONE_P   = {{ADDR_W{1'b0}}, 1'b1};

   initial begin
      assert (THR_W >= 1) else $error("sfifo_ctrl: THR_W must be at least 1");
      assert (LVL_SHIFT >= 0 && LVL_SHIFT <= 4) else $error("sfifo_ctrl: LVL_SHIFT out of range");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr, fill, fill_nxt;
   logic [CMP_W-1:0] fill_cmp, lvl_cmp;
   logic             empty, at_level, irq_q, sticky_q;

   assign fill      = wr_ptr - rd_ptr;
   assign empty     = (fill == '0);
   assign full_flag = (fill == DEPTH_V);
   assign rd_fire   = en & rd_req & ~empty;
   assign wr_fire   = en & wr_req & (~full_flag | rd_fire);
   assign wr_addr   = wr_ptr[ADDR_W-1:0];
   assign rd_addr   = rd_ptr[ADDR_W-1:0];

   always_comb begin
      fill_nxt = fill;
      if (wr_fire && !rd_fire) begin
         fill_nxt = fill + ONE_P;
      end else if (rd_fire && !wr_fire) begin
         fill_nxt = fill - ONE_P;
      end
   end

   assign fill_cmp = CMP_W'(fill_nxt);
   assign lvl_cmp  = CMP_W'(thr_code) << LVL_SHIFT;
   assign at_level = (fill_cmp >= lvl_cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else if (!en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
      end else begin
         if (wr_fire) wr_ptr <= wr_ptr + ONE_P;
         if (rd_fire) rd_ptr <= rd_ptr + ONE_P;
      end
   end

   // interrupt: set on reaching the level, released only by a read below it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (!en) begin
         irq_q <= 1'b0;
      end else if (rd_fire) begin
         irq_q <= at_level;
      end else if (at_level) begin
         irq_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky_q <= 1'b0;
      end else if (!en) begin
         sticky_q <= 1'b0;
      end else if (fill_nxt == DEPTH_V) begin
         sticky_q <= 1'b1;
      end
   end

   assign irq_flag   = irq_q;
   assign ovf_sticky = sticky_q;

   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= DEPTH_V);

   assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      en && wr_req && full_flag && !rd_req |=> wr_ptr == $past(wr_ptr));

   assert_empty_read_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      en && rd_req && empty |=> rd_ptr == $past(rd_ptr));

   assert_irq_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> ($past(rd_fire) || !$past(en)));

   assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      en && sticky_q |=> sticky_q);

   assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (fill == '0) && !irq_q && !sticky_q);

endmodule

// File: rtl/sfifo_pin_drv.sv
module sfifo_pin_drv #(
   parameter int N = 2
) (
   input  logic [N-1:0] flag,
   input  logic [N-1:0] active_high,
   output logic [N-1:0] pin
);

   initial begin
      assert (N >= 1) else $error("sfifo_pin_drv: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_pin
      assign pin[i] = sfifo_pkg::drive_level(flag[i], active_high[i]);
   end

endmodule

// File: rtl/sample_irq_fifo.sv
module sample_irq_fifo #(
   parameter int                      DATA_W      = 14,
   parameter int                      ADDR_W      = 4,
   parameter int                      THR_W       = 4,
   parameter int                      LVL_SHIFT   = 1,
   parameter sfifo_pkg::store_style_e STORE_STYLE = sfifo_pkg::STORE_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              smp_oor,
   input  logic              smp_valid,
   input  logic              rd_req,
   input  logic [THR_W-1:0]  thr_code,
   input  logic              irq_pol,
   input  logic              ovf_pol,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oor,
   output logic              irq_pin,
   output logic              ovf_pin,
   output logic              ovf_sticky
);

   localparam int WORD_W = DATA_W + 1;   // result plus out-of-range bit

   initial begin
      assert (DATA_W >= 1) else $error("sample_irq_fifo: DATA_W must be at least 1");
   end

   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic              wr_fire, rd_fire, irq_flag, full_flag;
   logic [WORD_W-1:0] in_word, store_word, out_q;
   logic [1:0]        pin_flags, pin_pols, pins;

   assign in_word = {smp_oor, smp_data};

   sfifo_ctrl #(
      .ADDR_W    (ADDR_W),
      .THR_W     (THR_W),
      .LVL_SHIFT (LVL_SHIFT)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (fifo_en),
      .wr_req     (smp_valid),
      .rd_req     (rd_req),
      .thr_code   (thr_code),
      .wr_addr    (wr_addr),
      .rd_addr    (rd_addr),
      .wr_fire    (wr_fire),
      .rd_fire    (rd_fire),
      .irq_flag   (irq_flag),
      .full_flag  (full_flag),
      .ovf_sticky (ovf_sticky)
   );

   sfifo_store #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .STYLE  (STORE_STYLE)
   ) i_store (
      .clk     (clk),
      .wr_en   (wr_fire),
      .wr_addr (wr_addr),
      .wr_word (in_word),
      .rd_addr (rd_addr),
      .rd_word (store_word)
   );

   // output register: per-clock capture when disabled, popped word when enabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
      end else if (!fifo_en) begin
         out_q <= in_word;
      end else if (rd_fire) begin
         out_q <= store_word;
      end
   end

   assign rd_data = out_q[DATA_W-1:0];
   assign rd_oor  = out_q[DATA_W];

   assign pin_flags = {full_flag, irq_flag};
   assign pin_pols  = {ovf_pol, irq_pol};

   sfifo_pin_drv #(.N(2)) i_pins (
      .flag        (pin_flags),
      .active_high (pin_pols),
      .pin         (pins)
   );

   assign irq_pin = pins[0];
   assign ovf_pin = pins[1];

   assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> {rd_oor, rd_data} == $past({smp_oor, smp_data}));

   assert_hold_without_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_en && !rd_req |=> $stable({rd_oor, rd_data}));

endmodule

// File: tb/test_sample_irq_fifo.sv
module test_sample_irq_fifo;

   localparam int DW    = 14;
   localparam int DEPTH = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 4 ns period

   logic          rst_n = 1'b0, fifo_en = 1'b0, smp_valid = 1'b0, smp_oor = 1'b0;
   logic          rd_req = 1'b0, irq_pol = 1'b1, ovf_pol = 1'b1;
   logic [DW-1:0] smp_data = '0;
   logic [3:0]    thr_code = '0;
   logic [DW-1:0] rd_data;
   logic          rd_oor, irq_pin, ovf_pin, ovf_sticky;

   sample_irq_fifo i_sample_irq_fifo (
      .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .smp_data(smp_data),
      .smp_oor(smp_oor), .smp_valid(smp_valid), .rd_req(rd_req),
      .thr_code(thr_code), .irq_pol(irq_pol), .ovf_pol(ovf_pol),
      .rd_data(rd_data), .rd_oor(rd_oor), .irq_pin(irq_pin),
      .ovf_pin(ovf_pin), .ovf_sticky(ovf_sticky)
   );

   int    total = 0, bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // behavioural reference
   logic [DW:0] mq[$];
   logic [DW:0] m_out = '0;
   bit          m_irq = 1'b0, m_sticky = 1'b0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit lvl(input bit f, input bit p);
      return p ? f : !f;
   endfunction

   task automatic compare_all();
      chk(cur_req, "read word", int'({rd_oor, rd_data}), int'(m_out));
      chk(cur_req, "irq_pin", int'(irq_pin), int'(lvl(m_irq, irq_pol)));
      chk(cur_req, "ovf_pin", int'(ovf_pin), int'(lvl(mq.size() == DEPTH, ovf_pol)));
      chk(cur_req, "ovf_sticky", int'(ovf_sticky), int'(m_sticky));
   endtask

   task automatic model_step();
      int n;
      bit rf, wf;
      int level;
      level = 2 * int'(thr_code);
      if (!fifo_en) begin
         mq.delete();
         m_out    = {smp_oor, smp_data};
         m_irq    = 1'b0;
         m_sticky = 1'b0;
      end else begin
         n  = mq.size();
         rf = rd_req && (n > 0);
         if (rf) m_out = mq.pop_front();
         wf = smp_valid && ((n < DEPTH) || rf);
         if (wf) mq.push_back({smp_oor, smp_data});
         if (rf) m_irq = (mq.size() >= level);
         else if (mq.size() >= level) m_irq = 1'b1;
         if (mq.size() == DEPTH) m_sticky = 1'b1;
      end
   endtask

   // called at a falling edge: drive, advance model, wait one clock, compare
   task automatic cyc(input bit en, input bit v, input logic [DW:0] w, input bit rd, input logic [3:0] thr);
      fifo_en   = en;
      smp_valid = v;
      {smp_oor, smp_data} = w;
      rd_req    = rd;
      thr_code  = thr;
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [DW:0] w;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "rd_data in reset", int'(rd_data), 0);
      chk("R1", "rd_oor in reset", int'(rd_oor), 0);
      chk("R1", "irq_pin in reset", int'(irq_pin), 0);
      chk("R1", "ovf_pin in reset", int'(ovf_pin), 0);
      chk("R1", "ovf_sticky in reset", int'(ovf_sticky), 0);
      irq_pol = 1'b0; ovf_pol = 1'b0;
      #0;
      chk("R1", "irq_pin low-active in reset", int'(irq_pin), 1);
      chk("R1", "ovf_pin low-active in reset", int'(ovf_pin), 1);
      irq_pol = 1'b1; ovf_pol = 1'b1;
      rst_n = 1'b1;

      // R2: disabled pass-through
      cur_req = "R2";
      for (int i = 0; i < 20; i++) begin
         w = (DW+1)'($urandom);
         cyc(1'b0, 1'($urandom), w, 1'($urandom), 4'($urandom));
         chk("R2", "pass-through word", int'({rd_oor, rd_data}), int'(w));
      end

      // R5: interrupt at level 2*code (code 3 -> 6)
      cur_req = "R5";
      for (int i = 0; i < 5; i++) begin
         cyc(1'b1, 1'b1, (DW+1)'(16'h100 + i), 1'b0, 4'd3);
         chk("R5", "irq below level", int'(irq_pin), 0);
      end
      cyc(1'b1, 1'b1, (DW+1)'(16'h105), 1'b0, 4'd3);
      chk("R5", "irq at level 6", int'(irq_pin), 1);

      // R6: release only on a read that drops below the level
      cur_req = "R6";
      cyc(1'b1, 1'b1, (DW+1)'(16'h106), 1'b0, 4'd3);
      cyc(1'b1, 1'b1, (DW+1)'(16'h107), 1'b0, 4'd3);
      cyc(1'b1, 1'b0, '0, 1'b0, 4'd7);
      chk("R6", "irq held after level raised", int'(irq_pin), 1);
      cyc(1'b1, 1'b0, '0, 1'b0, 4'd7);
      cyc(1'b1, 1'b0, '0, 1'b1, 4'd7);
      chk("R6", "irq released by read below level", int'(irq_pin), 0);
      cyc(1'b1, 1'b0, '0, 1'b0, 4'd3);
      chk("R6", "irq re-set at lower level", int'(irq_pin), 1);
      cyc(1'b1, 1'b0, '0, 1'b1, 4'd3);
      chk("R6", "irq held at count 6", int'(irq_pin), 1);
      cyc(1'b1, 1'b0, '0, 1'b1, 4'd3);
      chk("R6", "irq released at count 5", int'(irq_pin), 0);

      // R3: ordered drain
      cur_req = "R3";
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, '0, 1'b1, 4'd8);
      chk("R3", "last drained word", int'({rd_oor, rd_data}), 16'h107);
      for (int i = 0; i < 6; i++) begin
         cyc(1'b1, 1'b1, (DW+1)'(16'h4200 + i), i[0], 4'd8);
      end

      // R4: reads on empty hold the last value
      cur_req = "R4";
      for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, '0, 1'b1, 4'd8);
      chk("R4", "word held on empty read", int'({rd_oor, rd_data}), int'(m_out));
      cyc(1'b1, 1'b1, (DW+1)'(16'h2abc), 1'b0, 4'd8);
      cyc(1'b1, 1'b0, '0, 1'b1, 4'd8);
      chk("R4", "next write is next read", int'({rd_oor, rd_data}), 16'h2abc);

      // R7: fill to 16, extra writes dropped
      cur_req = "R7";
      for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b1, (DW+1)'(16'h1000 + i), 1'b0, 4'd15);
      chk("R7", "ovf_pin when full", int'(ovf_pin), 1);
      chk("R8", "sticky set on full", int'(ovf_sticky), 1);
      chk("R5", "level 30 unreachable", int'(irq_pin), 0);
      for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, (DW+1)'(16'h7000 + i), 1'b0, 4'd15);

      // R10: read and write together while full
      cur_req = "R10";
      cyc(1'b1, 1'b1, (DW+1)'(16'h3333), 1'b1, 4'd15);
      chk("R10", "oldest word out", int'({rd_oor, rd_data}), 16'h1000);
      chk("R10", "still full", int'(ovf_pin), 1);

      cur_req = "R7";
      cyc(1'b1, 1'b0, '0, 1'b1, 4'd15);
      chk("R7", "second word not overwritten", int'({rd_oor, rd_data}), 16'h1001);
      chk("R7", "ovf_pin off below 16", int'(ovf_pin), 0);
      for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, '0, 1'b1, 4'd15);
      chk("R10", "queued word last", int'({rd_oor, rd_data}), 16'h3333);

      // R8: sticky survives drain, clears on disable
      cur_req = "R8";
      cyc(1'b1, 1'b0, '0, 1'b0, 4'd15);
      chk("R8", "sticky after drain", int'(ovf_sticky), 1);
      cyc(1'b0, 1'b0, '0, 1'b0, 4'd15);
      chk("R8", "sticky cleared by disable", int'(ovf_sticky), 0);

      // R9: polarity
      cur_req = "R9";
      for (int i = 0; i < 7; i++) cyc(1'b1, 1'b1, (DW+1)'(16'h50 + i), 1'b0, 4'd2);
      for (int p = 0; p < 4; p++) begin
         irq_pol = p[0];
         ovf_pol = p[1];
         #0;
         chk("R9", "irq_pin polarity", int'(irq_pin), int'(lvl(1'b1, p[0])));
         chk("R9", "ovf_pin polarity", int'(ovf_pin), int'(lvl(1'b0, p[1])));
         cyc(1'b1, 1'b0, '0, 1'b0, 4'd2);
      end

      // R3: mixed traffic
      cur_req = "R3";
      for (int i = 0; i < 3000; i++) begin
         irq_pol = 1'($urandom);
         ovf_pol = 1'($urandom);
         cyc(($urandom % 50) != 0, ($urandom % 10) < 7, (DW+1)'($urandom),
             ($urandom % 10) < 4, 4'($urandom % 10));
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule